// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block takes a free-running 64-bit time value and freezes it at the moment a packet event is seen. There is one capture slot for the transmit direction and one for the receive direction. When an event qualifies, the slot copies the time, raises its valid flag and then locks. Any later event in that direction is dropped until software reads the high half of that slot. Because only one capture can be outstanding per direction, the stored time belongs without doubt to the single marked packet. The same high-half read is also the recovery step when a receive capture goes stale because its packet was dropped.

Receive events are qualified by a classifier that looks at the frame's descriptor fields. It can match frames carrying the precision-time EtherType, UDP event messages by destination port, or UDP event messages by both destination and source port. A separate stamp-everything mode does not use the receive slot. Instead it emits a 16-byte prefix for every received frame, with the time placed in its upper eight bytes. The time source, MAC framing and DMA all live outside this block.

Top module: `ts_capture_unit`

## Requirements
- R1: A `tx_event` pulse sampled while `tx_en` is 1 and `tx_valid` is 0 stores the `time_now` of that same clock edge in the transmit slot. `tx_valid` reads 1 from the next cycle.
- R2: While a slot's valid flag is 1, new events in that direction are ignored and the stored value does not change. This holds until the slot's high word is read.
- R3: A read of a slot's high word clears that slot's valid flag at the same edge. A read of the low word leaves the flag and the stored value as they are.
- R4: An event that arrives in the same cycle as the high-word read that frees its slot is captured, so the valid flag stays 1.
- R5: With the direction's enable at 0, no capture happens. Dropping the enable does not clear a slot that is already valid.
- R6: When `l2_en` is 1, a receive frame with `rx_ethertype` equal to 16'h88F7 qualifies for capture. Any other EtherType does not qualify through this path.
- R7: When `l4_en` is 1, a UDP frame with destination port 319 qualifies. When `l4_src_chk` is also 1, the source port must be 319 as well.
- R8: When `rx_all` is 1 and `rx_en` is 1, every `rx_sof` produces a one-cycle `pfx_valid` in the next cycle. Byte k of the prefix is `pfx_data[8k+7:8k]`. Bytes 0 to 7 are zero and bytes 8 to 15 hold the sampled time little-endian, with the low word in dword 2 and the high word in dword 3. In this mode the receive slot is not touched.
- R9: After reset both valid flags are 0, both slots hold zero, `rd_data` is 0 and `pfx_valid` is 0.
- R10: `rd_addr` selects the word to read: 0 is transmit low, 1 is transmit high, 2 is receive low and 3 is receive high. `rd_data` shows the selected word one cycle after `rd_en` and holds it until the next read. A high read returns the value held before the slot was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | TIME_W | Current time value |
| tx_en | input | 1 | Transmit capture enable |
| rx_en | input | 1 | Receive capture enable |
| rx_all | input | 1 | Stamp every received frame through the prefix |
| l2_en | input | 1 | EtherType match enable |
| l4_en | input | 1 | UDP event-port match enable |
| l4_src_chk | input | 1 | Also require UDP source port 319 |
| tx_event | input | 1 | Marked transmit packet event pulse |
| rx_sof | input | 1 | Received frame start, descriptor fields valid |
| rx_ethertype | input | 16 | Frame EtherType |
| rx_is_udp | input | 1 | Frame carries UDP |
| rx_dst_port | input | 16 | UDP destination port |
| rx_src_port | input | 16 | UDP source port |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Word select |
| rd_data | output | TIME_W/2 | Read data, registered |
| tx_valid | output | 1 | Transmit slot holds a capture |
| rx_valid | output | 1 | Receive slot holds a capture |
| pfx_valid | output | 1 | Prefix output strobe |
| pfx_data | output | 2*TIME_W | 16-byte per-packet prefix |

## Verification
A slot whose lock state is wrong shows up on `tx_valid` or `rx_valid` at the edge after the offending event or read. A corrupted stored time shows up only when the slot is read, one cycle after the read strobe. Because of that, the bench reads every capture back and also compares both flags on every cycle. Classifier faults appear as a receive capture that is missing or extra in the cycle after `rx_sof`. Prefix layout faults show in the same cycle as `pfx_valid`.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  typedef enum logic [1:0] {
    RA_TX_LO = 2'd0,
    RA_TX_HI = 2'd1,
    RA_RX_LO = 2'd2,
    RA_RX_HI = 2'd3
  } rd_sel_e;

  localparam logic [15:0] PTP_ETYPE    = 16'h88F7;
  localparam logic [15:0] PTP_EVT_PORT = 16'd319;
endpackage

// File: rtl/ts_rx_classifier.sv
module ts_rx_classifier
  import ts_cap_pkg::*;
(
  input  logic        l2_en,
  input  logic        l4_en,
  input  logic        src_chk,
  input  logic [15:0] etype,
  input  logic        is_udp,
  input  logic [15:0] dst_port,
  input  logic [15:0] src_port,
  output logic        match
);
  logic l2_hit;
  logic l4_hit;
  logic src_ok;

  always_comb begin
    l2_hit = l2_en && (etype == PTP_ETYPE);
    src_ok = !src_chk || (src_port == PTP_EVT_PORT);
    l4_hit = l4_en && is_udp && (dst_port == PTP_EVT_PORT) && src_ok;
    match  = l2_hit || l4_hit;
  end
endmodule

// File: rtl/ts_slot.sv
module ts_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         event_i,
  input  logic [W-1:0] time_i,
  input  logic         release_i,
  output logic         valid_o,
  output logic [W-1:0] cap_o
);
  logic free_now;
  logic take;

  always_comb begin
    free_now = !valid_o || release_i;
    take     = enable && event_i && free_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      cap_o   <= '0;
    end else if (take) begin
      valid_o <= 1'b1;
      cap_o   <= time_i;
    end else if (release_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_prefix_gen.sv
module ts_prefix_gen #(
  parameter int TIME_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [TIME_W-1:0]   time_i,
  output logic                pfx_valid,
  output logic [2*TIME_W-1:0] pfx_data
);
  localparam int PFX_W = 2 * TIME_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_valid <= 1'b0;
      pfx_data  <= '0;
    end else begin
      pfx_valid <= fire;
      if (fire) begin
        pfx_data[PFX_W-1:TIME_W] <= time_i;
        pfx_data[TIME_W-1:0]     <= '0;
      end
    end
  end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2,
  localparam int PFX_W  = 2 * TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_now,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              rx_all,
  input  logic              l2_en,
  input  logic              l4_en,
  input  logic              l4_src_chk,
  input  logic              tx_event,
  input  logic              rx_sof,
  input  logic [15:0]       rx_ethertype,
  input  logic              rx_is_udp,
  input  logic [15:0]       rx_dst_port,
  input  logic [15:0]       rx_src_port,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic              tx_valid,
  output logic              rx_valid,
  output logic              pfx_valid,
  output logic [PFX_W-1:0]  pfx_data
);
  logic              rx_match;
  logic              rx_evt;
  logic              pfx_fire;
  logic              tx_release;
  logic              rx_release;
  logic [TIME_W-1:0] tx_cap_w;
  logic [TIME_W-1:0] rx_cap_w;

  ts_rx_classifier u_cls (
    .l2_en    (l2_en),
    .l4_en    (l4_en),
    .src_chk  (l4_src_chk),
    .etype    (rx_ethertype),
    .is_udp   (rx_is_udp),
    .dst_port (rx_dst_port),
    .src_port (rx_src_port),
    .match    (rx_match)
  );

  always_comb begin
    rx_evt     = rx_sof && rx_match && !rx_all;
    pfx_fire   = rx_sof && rx_all && rx_en;
    tx_release = rd_en && (rd_addr == RA_TX_HI);
    rx_release = rd_en && (rd_addr == RA_RX_HI);
  end

  ts_slot #(.W(TIME_W)) u_tx_slot (
    .clk       (clk),
    .rst       (rst),
    .enable    (tx_en),
    .event_i   (tx_event),
    .time_i    (time_now),
    .release_i (tx_release),
    .valid_o   (tx_valid),
    .cap_o     (tx_cap_w)
  );

  ts_slot #(.W(TIME_W)) u_rx_slot (
    .clk       (clk),
    .rst       (rst),
    .enable    (rx_en),
    .event_i   (rx_evt),
    .time_i    (time_now),
    .release_i (rx_release),
    .valid_o   (rx_valid),
    .cap_o     (rx_cap_w)
  );

  ts_prefix_gen #(.TIME_W(TIME_W)) u_pfx (
    .clk       (clk),
    .rst       (rst),
    .fire      (pfx_fire),
    .time_i    (time_now),
    .pfx_valid (pfx_valid),
    .pfx_data  (pfx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_TX_LO: rd_data <= tx_cap_w[HALF_W-1:0];
        RA_TX_HI: rd_data <= tx_cap_w[TIME_W-1:HALF_W];
        RA_RX_LO: rd_data <= rx_cap_w[HALF_W-1:0];
        default:  rd_data <= rx_cap_w[TIME_W-1:HALF_W];
      endcase
    end
  end
endmodule

// File: rtl/ts_capture_checker.sv
module ts_capture_checker #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_event,
  input logic              rd_en,
  input logic [1:0]        rd_addr,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              pfx_valid,
  input logic [2*TIME_W-1:0] pfx_data,
  input logic [TIME_W-1:0] tx_cap
);
  logic tx_hi_rd;
  logic rx_hi_rd;
  assign tx_hi_rd = rd_en && (rd_addr == 2'd1);
  assign rx_hi_rd = rd_en && (rd_addr == 2'd3);

  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (rst) (tx_event && tx_en) |=> tx_valid); // R1
  AST_TX_LOCKED: assert property (@(posedge clk) disable iff (rst) (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_cap))); // R2
  AST_RX_LOCKED: assert property (@(posedge clk) disable iff (rst) (rx_valid && !rx_hi_rd) |=> rx_valid); // R2
  AST_HI_RELEASE: assert property (@(posedge clk) disable iff (rst) (tx_hi_rd && !tx_event) |=> !tx_valid); // R3
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (rst) (tx_hi_rd && tx_event && tx_en) |=> tx_valid); // R4
  AST_TX_DISABLED: assert property (@(posedge clk) disable iff (rst) (!tx_valid && !tx_en) |=> !tx_valid); // R5
  AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst) (!rx_valid && !rx_en) |=> !rx_valid); // R5
  AST_PFX_RESERVED: assert property (@(posedge clk) disable iff (rst) pfx_valid |-> (pfx_data[TIME_W-1:0] == '0)); // R8
endmodule

bind ts_capture_unit ts_capture_checker #(.TIME_W(TIME_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .tx_event (tx_event),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .tx_valid (tx_valid),
  .rx_valid (rx_valid),
  .pfx_valid(pfx_valid),
  .pfx_data (pfx_data),
  .tx_cap   (tx_cap_w)
);

// File: tb/tb_ts_capture_unit.sv
`timescale 1ns/1ps
module tb_ts_capture_unit;
  localparam int TW = 64;
  localparam int HW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [TW-1:0] time_now;
  logic tx_en, rx_en, rx_all, l2_en, l4_en, l4_src_chk;
  logic tx_event, rx_sof, rx_is_udp, rd_en;
  logic [15:0] rx_ethertype, rx_dst_port, rx_src_port;
  logic [1:0] rd_addr;
  logic [HW-1:0] rd_data;
  logic tx_valid, rx_valid, pfx_valid;
  logic [2*TW-1:0] pfx_data;

  ts_capture_unit #(.TIME_W(TW)) dut (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // time source
  always @(posedge clk) begin
    if (rst) time_now <= 64'h0123_4567_89AB_0000;
    else     time_now <= time_now + 64'd8;
  end

  // behavioural reference model
  logic m_txv, m_rxv, m_pv;
  logic [TW-1:0] m_txc, m_rxc;
  logic [HW-1:0] m_rd;
  logic [2*TW-1:0] m_pd;

  function automatic bit qualifies();
    bit hit = 0;
    if (l2_en && rx_ethertype == 16'h88F7) hit = 1;
    if (l4_en && rx_is_udp && rx_dst_port == 16'd319 &&
        (!l4_src_chk || rx_src_port == 16'd319)) hit = 1;
    return hit;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_txv <= 0; m_rxv <= 0; m_txc <= '0; m_rxc <= '0;
      m_rd <= '0; m_pv <= 0; m_pd <= '0;
    end else begin
      bit txhi, rxhi, rxe;
      txhi = rd_en && rd_addr == 2'd1;
      rxhi = rd_en && rd_addr == 2'd3;
      rxe  = rx_en && rx_sof && !rx_all && qualifies();
      if (tx_en && tx_event && (!m_txv || txhi)) begin m_txv <= 1; m_txc <= time_now; end
      else if (txhi) m_txv <= 0;
      if (rxe && (!m_rxv || rxhi)) begin m_rxv <= 1; m_rxc <= time_now; end
      else if (rxhi) m_rxv <= 0;
      if (rd_en) begin
        case (rd_addr)
          2'd0: m_rd <= m_txc[31:0];
          2'd1: m_rd <= m_txc[63:32];
          2'd2: m_rd <= m_rxc[31:0];
          default: m_rd <= m_rxc[63:32];
        endcase
      end
      m_pv <= rx_en && rx_all && rx_sof;
      if (rx_en && rx_all && rx_sof) m_pd <= {time_now, 64'd0};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(tx_valid === m_txv, "R1 R2 R3 R4 R5 tx_valid", 128'(tx_valid), 128'(m_txv));
      chk(rx_valid === m_rxv, "R6 R7 R2 rx_valid", 128'(rx_valid), 128'(m_rxv));
      chk(rd_data === m_rd, "R10 rd_data", 128'(rd_data), 128'(m_rd));
      chk(pfx_valid === m_pv, "R8 pfx_valid", 128'(pfx_valid), 128'(m_pv));
      if (m_pv) chk(pfx_data === m_pd, "R8 pfx_data", pfx_data, m_pd);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle();
    tx_event = 0; rx_sof = 0; rd_en = 0; rd_addr = 0;
    rx_ethertype = 16'h0800; rx_is_udp = 0; rx_dst_port = 0; rx_src_port = 0;
  endtask

  task automatic step(); @(negedge clk); idle(); endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; rd_addr = a; step();
  endtask

  task automatic frame(input logic [15:0] et, input bit udp, input logic [15:0] dp, input logic [15:0] sp);
    rx_sof = 1; rx_ethertype = et; rx_is_udp = udp; rx_dst_port = dp; rx_src_port = sp; step();
  endtask

  logic [TW-1:0] t_exp;

  initial begin
    rst = 1; tx_en = 0; rx_en = 0; rx_all = 0; l2_en = 0; l4_en = 0; l4_src_chk = 0;
    idle();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(!tx_valid && !rx_valid && !pfx_valid, "R9 flags after reset", 128'({tx_valid, rx_valid, pfx_valid}), 128'(0));
    chk(rd_data == 0, "R9 rd_data after reset", 128'(rd_data), 128'(0));
    rd(2'd1); step();
    chk(rd_data == 0, "R9 tx high word zero after reset", 128'(rd_data), 128'(0));

    // R1 capture
    tx_en = 1;
    tx_event = 1; t_exp = time_now; step();
    chk(tx_valid == 1, "R1 tx capture", 128'(tx_valid), 128'(1));
    // R2 locked
    tx_event = 1; step(); step();
    rd(2'd0);
    chk(rd_data == t_exp[31:0], "R2 R10 tx low word", 128'(rd_data), 128'(t_exp[31:0]));
    chk(tx_valid == 1, "R3 low read keeps valid", 128'(tx_valid), 128'(1));
    rd(2'd1);
    chk(rd_data == t_exp[63:32], "R3 R10 tx high word", 128'(rd_data), 128'(t_exp[63:32]));
    chk(tx_valid == 0, "R3 high read releases", 128'(tx_valid), 128'(0));

    // R4 same-cycle release and event
    tx_event = 1; step();
    tx_event = 1; rd_en = 1; rd_addr = 2'd1; t_exp = time_now; step();
    chk(tx_valid == 1, "R4 event on release edge captured", 128'(tx_valid), 128'(1));
    rd(2'd0);
    chk(rd_data == t_exp[31:0], "R4 new capture value", 128'(rd_data), 128'(t_exp[31:0]));

    // R5 disable keeps valid, blocks new
    tx_en = 0; step(); step();
    chk(tx_valid == 1, "R5 disable keeps valid", 128'(tx_valid), 128'(1));
    rd(2'd1);
    tx_event = 1; step(); step();
    chk(tx_valid == 0, "R5 disabled no capture", 128'(tx_valid), 128'(0));

    // R6 layer-2 match
    rx_en = 1; l2_en = 1;
    frame(16'h0800, 0, 0, 0);
    chk(rx_valid == 0, "R6 other ethertype ignored", 128'(rx_valid), 128'(0));
    t_exp = time_now; frame(16'h88F7, 0, 0, 0);
    chk(rx_valid == 1, "R6 ethertype match", 128'(rx_valid), 128'(1));
    frame(16'h88F7, 0, 0, 0);  // stale lock: ignored
    rd(2'd3);
    chk(rd_data == t_exp[63:32], "R2 R6 rx high word held", 128'(rd_data), 128'(t_exp[63:32]));
    chk(rx_valid == 0, "R3 rx recovery by high read", 128'(rx_valid), 128'(0));

    // R7 layer-4 match
    l2_en = 0; l4_en = 1;
    frame(16'h0800, 0, 319, 319);
    chk(rx_valid == 0, "R7 non-udp ignored", 128'(rx_valid), 128'(0));
    frame(16'h0800, 1, 320, 319);
    chk(rx_valid == 0, "R7 wrong dst ignored", 128'(rx_valid), 128'(0));
    l4_src_chk = 1;
    frame(16'h0800, 1, 319, 1234);
    chk(rx_valid == 0, "R7 src check rejects", 128'(rx_valid), 128'(0));
    frame(16'h0800, 1, 319, 319);
    chk(rx_valid == 1, "R7 src check accepts", 128'(rx_valid), 128'(1));
    rd(2'd3);
    l4_src_chk = 0;
    frame(16'h0800, 1, 319, 1234);
    chk(rx_valid == 1, "R7 dst only accepts", 128'(rx_valid), 128'(1));
    rd(2'd3);

    // R8 stamp-all prefix
    rx_all = 1;
    t_exp = time_now; frame(16'h88F7, 1, 319, 319);
    chk(pfx_valid == 1, "R8 prefix strobe", 128'(pfx_valid), 128'(1));
    chk(pfx_data == {t_exp, 64'd0}, "R8 prefix layout", pfx_data, {t_exp, 64'd0});
    chk(rx_valid == 0, "R8 slot untouched", 128'(rx_valid), 128'(0));
    step();
    chk(pfx_valid == 0, "R8 strobe one cycle", 128'(pfx_valid), 128'(0));
    rx_all = 0;

    // mixed pseudo-random traffic, model compared each cycle
    for (int i = 0; i < 3000; i++) begin
      tx_en = ($urandom_range(0, 9) != 0);
      rx_en = ($urandom_range(0, 9) != 0);
      rx_all = ($urandom_range(0, 7) == 0);
      l2_en = $urandom_range(0, 1); l4_en = $urandom_range(0, 1);
      l4_src_chk = $urandom_range(0, 1);
      tx_event = ($urandom_range(0, 3) == 0);
      rx_sof = ($urandom_range(0, 2) == 0);
      rx_ethertype = $urandom_range(0, 1) ? 16'h88F7 : 16'h0800;
      rx_is_udp = $urandom_range(0, 1);
      rx_dst_port = $urandom_range(0, 1) ? 16'd319 : 16'd320;
      rx_src_port = $urandom_range(0, 1) ? 16'd319 : 16'd5000;
      rd_en = ($urandom_range(0, 3) == 0);
      rd_addr = 2'($urandom_range(0, 3));
      step();
    end
    step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule